// File: doc/BRIEF.md
# Serial Command Word Receiver

This block is the slave end of a four-wire serial link. A host sends one 16-bit word per chip-select pulse, most significant bit first. The upper four bits of the word name a command and the lower twelve bits carry its argument. When chip select is released after a complete word, the block applies the word to one of its internal targets: a 12-bit operating-mode register, or a single trace-enable flag.

The serial clock, data line and chip select are brought into the system clock domain through two-flop synchronisers. All decoding then runs on the system clock. For this reason the system clock must run at least four times faster than the serial clock. Each accepted word raises a one-cycle strobe in the same cycle as the register it updates. Words of the wrong length are dropped, and so are words whose command is not recognised.

Top module: `spi_cmd_rx`

## Requirements
- R1: A word is 16 bits, captured most significant bit first. Bits 15..12 are the command and bits 11..0 are the data.
- R2: Command code 4'h1 loads the 12 data bits into `mode_o`.
- R3: Command code 4'h2 sets `trace_o` to data bit 0. Data bits 11..1 have no effect.
- R4: A word is discarded, changing no output and raising no strobe, when chip select rises after any number of rising serial-clock edges other than 16 (for example 15 or 17).
- R5: A complete word with any command code other than 4'h1 or 4'h2 changes no output and raises no strobe.
- R6: `cmd_stb_o` is high for exactly one system-clock cycle per accepted word. `mode_o` and `trace_o` take their new values in that same cycle.
- R7: While reset is held and afterwards until the first accepted word, `mode_o` is 12'h000 (front end off), `trace_o` is 0 and `cmd_stb_o` is 0.
- R8: The strobe and the register update appear after the third rising system-clock edge at or after the rise of `cs_n`.
- R9: Data is sampled on the rising serial-clock edge. The line may change on the falling edge while the serial clock idles low.
- R10: Serial-clock edges while chip select is high shift nothing and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sck | input | 1 | Serial clock from the host, idles low |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Chip select, active low, one pulse per word |
| mode_o | output | 12 | Operating-mode register |
| trace_o | output | 1 | Trace-enable flag |
| cmd_stb_o | output | 1 | One-cycle pulse for each accepted word |

## Verification
Every result of this block is due on one exact cycle: three rising system-clock edges after the bench releases chip select. That delay is made up of two synchroniser flops and one dispatch register. The driver records the cycle number at which it raises `cs_n` and queues the expected mode, trace flag and due cycle. The monitor samples on the falling clock edge, and each time it sees the strobe it compares the actual cycle and values against the head of the queue. A strobe with an empty queue is a failure. Dropped words are checked by reading `mode_o` and `trace_o` directly after a settling gap and confirming that no strobe reached the monitor.

// File: rtl/spi_cmd_pkg.sv
// Shared widths, command codes and frame layout for the serial command receiver.
package spi_cmd_pkg;
    localparam int FRAME_W = 16;
    localparam int CMD_W   = 4;
    localparam int DATA_W  = FRAME_W - CMD_W;

    typedef logic [CMD_W-1:0]  cmd_t;
    typedef logic [DATA_W-1:0] data_t;

    // Recognised command codes; anything else is ignored.
    typedef enum logic [CMD_W-1:0] {
        OP_SET_MODE  = 4'h1,
        OP_SET_TRACE = 4'h2
    } op_e;

    // Command sits in the upper bits, data in the lower bits.
    typedef struct packed {
        cmd_t  cmd;
        data_t data;
    } frame_t;
endpackage

// File: rtl/spi_sync.sv
// Multi-bit, multi-stage synchroniser.
// Assumes each bit is an independent level that stays stable for several
// clk cycles, so bits need no mutual coherence beyond that.
module spi_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d_i;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each later stage re-times the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_deser.sv
// Serial-to-parallel converter working on synchronised serial lines.
// Shifts one bit in on each rising serial-clock edge while chip select is low,
// counts those edges, and flags a frame when chip select rises after exactly
// FRAME_W edges. Assumes clk is at least 4x the serial clock.
module spi_deser #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               mosi_s,
    input  logic               cs_n_s,
    output logic               frame_vld_o,
    output logic [FRAME_W-1:0] frame_o
);
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int CNT_MAX = FRAME_W + 1;

    logic             sck_d, cs_d;
    logic [CNT_W-1:0] edge_cnt;
    logic [FRAME_W-1:0] shreg;
    logic             sck_rise, cs_rise;

    assign sck_rise = sck_s & ~sck_d;
    assign cs_rise  = cs_n_s & ~cs_d;

    // Delayed copies of the synchronised lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
        end
    end

    // Edge counter: cleared while deselected, saturates one past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       edge_cnt <= '0;
        else if (cs_n_s)                                  edge_cnt <= '0;
        else if (sck_rise && edge_cnt != CNT_W'(CNT_MAX)) edge_cnt <= edge_cnt + 1'b1;
    end

    // Shift register: MSB arrives first and ends at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                  shreg <= '0;
        else if (!cs_n_s && sck_rise) shreg <= {shreg[FRAME_W-2:0], mosi_s};
    end

    assign frame_vld_o = cs_rise && (edge_cnt == CNT_W'(FRAME_W));
    assign frame_o     = shreg;

    // R4: the edge counter never passes its saturation value.
    assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/spi_dispatch.sv
// Decodes a complete frame and writes the addressed target register.
// Assumes frame_vld_i is a single-cycle pulse with frame_i stable alongside it.
module spi_dispatch
    import spi_cmd_pkg::*;
#(
    parameter logic [DATA_W-1:0] MODE_OFF = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_vld_i,
    input  frame_t            frame_i,
    output logic [DATA_W-1:0] mode_o,
    output logic              trace_o,
    output logic              stb_o
);
    logic hit_mode, hit_trace;

    // Command decode.
    always_comb begin
        hit_mode  = frame_vld_i && (frame_i.cmd == OP_SET_MODE);
        hit_trace = frame_vld_i && (frame_i.cmd == OP_SET_TRACE);
    end

    // Target registers and acceptance strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o  <= MODE_OFF;
            trace_o <= 1'b0;
            stb_o   <= 1'b0;
        end else begin
            stb_o <= hit_mode | hit_trace;
            if (hit_mode)  mode_o  <= frame_i.data;
            if (hit_trace) trace_o <= frame_i.data[0];
        end
    end

    // R6: the strobe never lasts two cycles.
    assert_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o);
    // R5: the mode register only moves together with the strobe.
    assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> stb_o);
    // R5: the trace flag only moves together with the strobe.
    assert_trace_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trace_o) |-> stb_o);
endmodule

// File: rtl/spi_cmd_rx.sv
// Serial command word receiver top level.
// Synchronises the serial lines, deserialises one word per chip-select pulse
// and dispatches it to the mode register or the trace flag.
// Assumes clk runs at least 4x the serial clock rate.
module spi_cmd_rx
    import spi_cmd_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] MODE_OFF    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              cs_n,
    output logic [DATA_W-1:0] mode_o,
    output logic              trace_o,
    output logic              cmd_stb_o
);
    logic [2:0]         lines_s;
    logic               frame_vld;
    logic [FRAME_W-1:0] frame_bits;

    spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n, mosi, sck}),
        .q_o   (lines_s)
    );

    spi_deser #(.FRAME_W(FRAME_W)) u_deser (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_s       (lines_s[0]),
        .mosi_s      (lines_s[1]),
        .cs_n_s      (lines_s[2]),
        .frame_vld_o (frame_vld),
        .frame_o     (frame_bits)
    );

    spi_dispatch #(.MODE_OFF(MODE_OFF)) u_disp (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_vld_i (frame_vld),
        .frame_i     (frame_t'(frame_bits)),
        .mode_o      (mode_o),
        .trace_o     (trace_o),
        .stb_o       (cmd_stb_o)
    );

    // R10: a strobe requires chip select to have been released recently.
    assert_stb_after_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o |-> lines_s[2]);
endmodule

// File: tb/spi_cmd_rx_tb_top.sv
module spi_cmd_rx_tb_top;
    localparam int HALF = 4;   // clk cycles per serial-clock half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic [11:0] mode_o;
    logic trace_o, cmd_stb_o;

    always #4 clk = ~clk;   // 125 MHz

    spi_cmd_rx dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .mode_o(mode_o), .trace_o(trace_o), .cmd_stb_o(cmd_stb_o)
    );

    typedef struct {
        int          due;
        logic [11:0] mode;
        logic        trace;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          cyc = 0;
    int          n_chk = 0, n_fail = 0;
    logic [11:0] exp_mode = 12'h000;
    logic        exp_trace = 1'b0;
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: every strobe must match the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && cmd_stb_o && !done) begin
            if (sb_q.size() == 0) begin
                check(0, "R5", "unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(cyc == e.due, e.req, "strobe cycle (R8)", cyc, e.due);
                check(mode_o == e.mode, e.req, "mode", mode_o, e.mode);
                check(trace_o == e.trace, e.req, "trace", trace_o, e.trace);
            end
        end
    end

    // Driver: send nbits of word MSB first, then release chip select.
    task automatic send(input logic [31:0] word, input int nbits,
                        input bit accept, input string req);
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = word[i];                   // change while SCK is low (R9)
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
            mosi = ~mosi;                     // disturb line on falling edge (R9)
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        if (accept) begin
            exp_t e;
            e.due = cyc + 3; e.mode = exp_mode; e.trace = exp_trace; e.req = req;
            sb_q.push_back(e);
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic send_mode(input logic [11:0] v);
        exp_mode = v;
        send({16'h0, 4'h1, v}, 16, 1, "R2");
    endtask

    task automatic send_trace(input logic [11:0] v);
        exp_trace = v[0];
        send({16'h0, 4'h2, v}, 16, 1, "R3");
    endtask

    task automatic check_hold(input string req);
        check(mode_o == exp_mode, req, "mode held", mode_o, exp_mode);
        check(trace_o == exp_trace, req, "trace held", trace_o, exp_trace);
        check(sb_q.size() == 0, req, "pending strobes", sb_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state while held and just after release
        check(mode_o == 12'h000, "R7", "mode in reset", mode_o, 0);
        check(trace_o == 1'b0, "R7", "trace in reset", trace_o, 0);
        check(cmd_stb_o == 1'b0, "R7", "strobe in reset", cmd_stb_o, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(mode_o == 12'h000, "R7", "mode after reset", mode_o, 0);

        // R1, R2: several data patterns, MSB first
        send_mode(12'hA5C);
        send_mode(12'h001);
        send_mode(12'h800);
        send_mode(12'hFFF);
        // R3: only data bit 0 matters
        send_trace(12'h001);
        send_trace(12'hFFE);
        send_trace(12'h7FF);
        check_hold("R3");
        // R4: short and long frames dropped
        send({16'h0, 4'h1, 12'h123} >> 1, 15, 0, "R4");
        check_hold("R4");
        send({15'h0, 4'h1, 12'h456, 1'b1}, 17, 0, "R4");
        check_hold("R4");
        // R5: unknown commands ignored
        send({16'h0, 4'h0, 12'h3C3}, 16, 0, "R5");
        send({16'h0, 4'hF, 12'h0F1}, 16, 0, "R5");
        send({16'h0, 4'h3, 12'h001}, 16, 0, "R5");
        check_hold("R5");
        // R10: serial clock toggles while deselected
        for (int i = 0; i < 20; i++) begin
            mosi = i[0];
            repeat (HALF) @(negedge clk); sck = 1'b1;
            repeat (HALF) @(negedge clk); sck = 1'b0;
        end
        repeat (10) @(negedge clk);
        check_hold("R10");
        // R6: back-to-back accepted words, then a final update
        send_mode(12'h3A6);
        send_trace(12'h000);
        send_mode(12'h000);
        repeat (10) @(negedge clk);
        check_hold("R6");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule